// File: doc/BRIEF.md
# Condition Field Masked Predicate Unit

This unit holds a file of eight 4-bit condition fields and runs one masked operation per accepted request. An operation selects four bits: a source condition field, or the low four bits of a 64-bit integer operand. It compares each selected bit with the matching mode bit, then keeps the result only where the mask bit is set. The result either updates a destination condition field or comes back as a 64-bit integer. A fourth operation copies a source field into a destination field under the mask and XORs in the mode, so each bit can be copied, inverted, set or cleared in place.

A merge flag picks between two ways of writing the destination. With the flag set, the bits outside the mask keep their old value, which makes the write a read-modify-write. With the flag clear, the whole field is overwritten. The request port always accepts. Results, the write strobe and the field update all appear one clock after acceptance. A combinational read port lets the surrounding logic observe any field.

Top module: `cfield_pred_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, all eight fields read 0000 and `res_valid`, `res_illegal` and `cf_we` are 0.
- R2: `req_ready` is always 1. A request with `req_valid`=1 is accepted on a rising edge. `res_valid` and any field write appear after that edge and last exactly one cycle. With no accepted request, `res_valid` and `cf_we` are 0.
- R3: Opcode 0 (field compare to field) computes pred[i] = mask[i] & (mode[i] == field[src][i]) and writes it to field `req_dst`.
- R4: Opcode 1 (field compare to integer) computes pred as in R3. It returns `res_int` = pred in bits 3:0 with bits 63:4 zero, and writes no field.
- R5: Opcode 2 (integer compare to field) computes pred[i] = mask[i] & (mode[i] == operand[i]), with bit 0 the least significant bit of the operand. The operand is `req_int`, or zero when `req_rsel` is 0. The result is written to field `req_dst`.
- R6: For opcodes 0 and 2, merge=1 writes pred into the masked bits and keeps the old destination value in the unmasked bits. Merge=0 writes pred as-is, so the unmasked bits become 0.
- R7: Opcode 3 (masked move) writes ((mask & src) ^ mode) to `req_dst` when merge=0. When merge=1 it writes (((mask & src) | (~mask & old)) ^ mode). No bit changes position.
- R8: Opcode 2 with a zero operand gives three results. Merge=0, mask=1111 and mode=~imm load imm. Merge=1 with mode=0000 sets the masked bits. Merge=1 with mode=1111 clears the masked bits.
- R9: Opcodes 4 to 7 give `res_illegal`=1 and `res_int`=0 with `res_valid`, and write no field.
- R10: `rd_field` always shows the current content of field `rd_idx`. A write is visible there from the edge that raises `cf_we`.
- R11: Back-to-back requests read the field contents as left by the previous request.
- R12: Along with each write, `cf_we` pulses with `cf_waddr` = `req_dst` and `cf_wdata` = the value written. `res_int` is 0 for every opcode except 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (always 1) |
| req_op | input | 3 | Opcode 0..3; 4..7 are illegal |
| req_src | input | 3 | Source field index |
| req_dst | input | 3 | Destination field index |
| req_rsel | input | 5 | Integer operand register index; 0 selects literal zero |
| req_int | input | 64 | Integer operand value |
| req_mask | input | 4 | Bit mask |
| req_mode | input | 4 | Mode bits |
| req_merge | input | 1 | 1 = keep unmasked bits, 0 = overwrite |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_int | output | 64 | Integer result |
| res_illegal | output | 1 | Illegal opcode flag |
| cf_we | output | 1 | Field write strobe |
| cf_waddr | output | 3 | Written field index |
| cf_wdata | output | 4 | Written field value |
| rd_idx | input | 3 | Read port field index |
| rd_field | output | 4 | Read port field value |

## Verification
A behavioural model in the bench tracks all eight fields. After every edge, the bench compares the model with the result port and with a sweep of the read port.

The directed patterns cover the following:
- The three immediate, set and clear operand settings, which tell the two merge behaviours apart.
- A nonzero integer with register index 0, which shows that the literal zero is used.
- Mode values of 0000 and 1111 on the move, which tell copy from invert.
- Back-to-back requests on one field, which show that the read-modify-write uses the freshly written value.

A long random run mixes all eight opcodes, including the illegal ones.

// File: rtl/cfield_pred_unit.sv
module cfield_pred_unit #(
  parameter int NFIELDS = 8,
  parameter int FW      = 4,
  parameter int XLEN    = 64,
  parameter int RSELW   = 5,
  localparam int AW     = $clog2(NFIELDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_src,
  input  logic [AW-1:0]   req_dst,
  input  logic [RSELW-1:0] req_rsel,
  input  logic [XLEN-1:0] req_int,
  input  logic [FW-1:0]   req_mask,
  input  logic [FW-1:0]   req_mode,
  input  logic            req_merge,
  output logic            res_valid,
  output logic [XLEN-1:0] res_int,
  output logic            res_illegal,
  output logic            cf_we,
  output logic [AW-1:0]   cf_waddr,
  output logic [FW-1:0]   cf_wdata,
  input  logic [AW-1:0]   rd_idx,
  output logic [FW-1:0]   rd_field
);
  localparam logic [2:0] OP_F2F = 3'd0, OP_F2I = 3'd1, OP_I2F = 3'd2, OP_MOV = 3'd3;

  logic [FW-1:0] cf [NFIELDS];

  logic            accept, illegal, writes, is_cmp;
  logic [XLEN-1:0] opnd;
  logic [FW-1:0]   src_f, old_f, cmp_f, pred, keep, wval;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;
  assign illegal   = req_op[2];
  assign is_cmp    = (req_op == OP_F2F) || (req_op == OP_I2F);
  assign writes    = is_cmp || (req_op == OP_MOV);

  assign opnd  = (req_rsel == '0) ? '0 : req_int;
  assign src_f = cf[req_src];
  assign old_f = cf[req_dst];
  assign cmp_f = (req_op == OP_I2F) ? opnd[FW-1:0] : src_f;
  assign pred  = req_mask & ~(req_mode ^ cmp_f);
  assign keep  = req_merge ? (old_f & ~req_mask) : '0;

  always_comb begin
    if (req_op == OP_MOV) wval = ((req_mask & src_f) | keep) ^ req_mode;
    else                  wval = pred | keep;
  end

  assign rd_field = cf[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELDS; i++) cf[i] <= '0;
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_int     <= '0;
      cf_we       <= 1'b0;
      cf_waddr    <= '0;
      cf_wdata    <= '0;
    end else begin
      res_valid   <= accept;
      res_illegal <= accept & illegal;
      res_int     <= (accept && req_op == OP_F2I) ? XLEN'(pred) : '0;
      cf_we       <= accept & writes;
      if (accept && writes) begin
        cf[req_dst] <= wval;
        cf_waddr    <= req_dst;
        cf_wdata    <= wval;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!res_valid && !cf_we));
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_valid && !cf_we && res_int == '0));
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_int[XLEN-1:FW] == '0));
  a_r6_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_cmp && !req_merge) |=> ((cf_wdata & ~$past(req_mask)) == '0));
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_cmp && req_merge) |=>
      ((cf_wdata & ~$past(req_mask)) == ($past(old_f) & ~$past(req_mask))));
  a_r10_visible: assert property (@(posedge clk) disable iff (!rst_n)
    cf_we |-> (cf[cf_waddr] == cf_wdata));
endmodule

// File: tb/cfield_pred_unit_test.sv
`timescale 1ns/10ps
module cfield_pred_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [2:0]  req_src = '0, req_dst = '0;
  logic [4:0]  req_rsel = '0;
  logic [63:0] req_int = '0;
  logic [3:0]  req_mask = '0, req_mode = '0;
  logic        req_merge = 1'b0;
  logic        res_valid, res_illegal, cf_we;
  logic [63:0] res_int;
  logic [2:0]  cf_waddr;
  logic [3:0]  cf_wdata;
  logic [2:0]  rd_idx = '0;
  logic [3:0]  rd_field;

  int tests = 0, fails = 0;
  logic [3:0] model [8];

  cfield_pred_unit uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.1;
      chk(tag, $sformatf("field %0d", i), 64'(rd_field), 64'(model[i]));
    end
  endtask

  task automatic send(input string tag, input logic [2:0] op, input logic [2:0] src, input logic [2:0] dst,
                      input logic [4:0] rsel, input logic [63:0] ival,
                      input logic [3:0] mask, input logic [3:0] mode, input logic merge);
    logic [3:0] sf, of, cmpv, pr, wv;
    logic [63:0] opnd, eint;
    logic ewr, eill;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src = src; req_dst = dst; req_rsel = rsel;
    req_int = ival; req_mask = mask; req_mode = mode; req_merge = merge;
    opnd = (rsel == 0) ? 64'd0 : ival;
    sf = model[src]; of = model[dst];
    cmpv = (op == 3'd2) ? opnd[3:0] : sf;
    for (int b = 0; b < 4; b++) pr[b] = mask[b] && (mode[b] == cmpv[b]);
    eill = (op >= 3'd4);
    ewr = (op == 3'd0) || (op == 3'd2) || (op == 3'd3);
    eint = (op == 3'd1) ? {60'd0, pr} : 64'd0;
    for (int b = 0; b < 4; b++) begin
      if (op == 3'd3) wv[b] = ((mask[b] ? sf[b] : (merge ? of[b] : 1'b0))) ^ mode[b];
      else            wv[b] = mask[b] ? pr[b] : (merge ? of[b] : 1'b0);
    end
    @(posedge clk);
    #1;
    chk(tag, "res_valid", 64'(res_valid), 64'd1);
    chk(tag, "res_illegal", 64'(res_illegal), 64'(eill));
    chk(tag, "res_int", res_int, eint);
    chk(tag, "cf_we", 64'(cf_we), 64'(ewr));
    if (ewr) begin
      chk(tag, "cf_waddr", 64'(cf_waddr), 64'(dst));
      chk(tag, "cf_wdata", 64'(cf_wdata), 64'(wv));
      model[dst] = wv;
    end
    sweep(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    req_op = 3'd3; req_mask = 4'hf; req_mode = 4'hf;
    @(posedge clk);
    #1;
    chk(tag, "idle res_valid", 64'(res_valid), 64'd0);
    chk(tag, "idle cf_we", 64'(cf_we), 64'd0);
    sweep(tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "res_valid in reset", 64'(res_valid), 64'd0);
    chk("R1", "cf_we in reset", 64'(cf_we), 64'd0);
    chk("R2", "ready", 64'(req_ready), 64'd1);
    sweep("R1");
    @(negedge clk); rst_n = 1'b1;
    idle("R1");

    // R8: immediate load, set, clear with zero operand
    send("R8", 3'd2, 0, 2, 5'd0, 64'h0, 4'b1111, ~4'b1010, 1'b0);
    chk("R8", "imm load", 64'(model[2]), 64'hA);
    send("R8", 3'd2, 0, 2, 5'd0, 64'h0, 4'b0101, 4'b0000, 1'b1);
    chk("R8", "set bits", 64'(model[2]), 64'hF);
    send("R8", 3'd2, 0, 2, 5'd0, 64'h0, 4'b0011, 4'b1111, 1'b1);
    chk("R8", "clear bits", 64'(model[2]), 64'hC);

    // R5: integer compare, nonzero index vs literal zero
    send("R5", 3'd2, 0, 1, 5'd7, 64'hFFFF_0000_0000_0006, 4'b1111, 4'b1111, 1'b0);
    chk("R5", "int bits", 64'(model[1]), 64'h6);
    send("R5", 3'd2, 0, 3, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1111, 4'b1111, 1'b0);
    chk("R5", "rsel zero", 64'(model[3]), 64'h0);

    // R3 / R6
    send("R3", 3'd0, 2, 4, 5'd0, 64'h0, 4'b1111, 4'b1100, 1'b0);
    send("R6", 3'd0, 1, 2, 5'd0, 64'h0, 4'b0110, 4'b0110, 1'b1);
    send("R6", 3'd0, 1, 4, 5'd0, 64'h0, 4'b0011, 4'b0000, 1'b0);

    // R4
    send("R4", 3'd1, 1, 5, 5'd0, 64'h0, 4'b1111, 4'b0110, 1'b0);
    send("R4", 3'd1, 2, 5, 5'd0, 64'h0, 4'b1010, 4'b0000, 1'b1);

    // R7: copy, invert, set, clear
    send("R7", 3'd3, 1, 6, 5'd0, 64'h0, 4'b1111, 4'b0000, 1'b0);
    send("R7", 3'd3, 1, 7, 5'd0, 64'h0, 4'b1111, 4'b1111, 1'b0);
    send("R7", 3'd3, 0, 6, 5'd0, 64'h0, 4'b0000, 4'b1001, 1'b1);
    send("R7", 3'd3, 2, 7, 5'd0, 64'h0, 4'b0011, 4'b0000, 1'b1);

    // R9
    for (int o = 4; o < 8; o++) send("R9", 3'(o), 2, 2, 5'd0, 64'h0, 4'hF, 4'h0, 1'b0);

    // R11 back-to-back on one field; R12 strobe contents checked in send
    send("R11", 3'd2, 0, 0, 5'd0, 64'h0, 4'b0001, 4'b0000, 1'b1);
    send("R11", 3'd2, 0, 0, 5'd0, 64'h0, 4'b0100, 4'b0000, 1'b1);
    send("R12", 3'd3, 0, 0, 5'd0, 64'h0, 4'b1111, 4'b0010, 1'b1);
    idle("R10");

    for (int k = 0; k < 300; k++) begin
      send("R12", 3'($urandom_range(0, 7)), 3'($urandom), 3'($urandom), 5'($urandom),
           {$urandom, $urandom}, 4'($urandom), 4'($urandom), 1'($urandom));
      if (k % 17 == 0) idle("R2");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule